// File: doc/BRIEF.md
# Boost Converter Supply Protection Supervisor

This block is the digital supervisor that decides when every phase of a multiphase boost converter must stop switching. It watches a digitized boost-output voltage code against a programmed trip code. When the voltage rises above the trip code, it holds all phases off. It lets them run again only after the voltage has fallen below the trip code minus a programmable release margin. A sticky overvoltage flag records the event, and a status-read strobe clears it once the condition has gone.

The block also acts on a gate-drive undervoltage comparator. That result is ignored during a start-up blanking window after reset is released. A selection code of zero disables it, and it is debounced by a programmable count of consecutive cycles before it locks the phases off. Per-phase status bits report 1 while a phase may switch and 0 while it is held off.

State machines:
- Overvoltage machine. States: `OV_RUN` and `OV_TRIP`. Transitions: trip (RUN to TRIP) when the voltage code exceeds the trip code, and release (TRIP to RUN) when the voltage code plus the release margin is below the trip code.
- Undervoltage machine. States: `UV_BLANK`, `UV_WATCH` and `UV_LOCK`. Transitions: blank-expire (BLANK to WATCH) after `BLANK_CYC` clock edges, lock (WATCH to LOCK) after the debounce count, and recover (LOCK to WATCH) when the comparator is low or the function is disabled.

Top module: `boost_guard`

## Requirements
- R1: After reset, `pwm_inhibit` is all 0, `phase_ok` is all 1 and `ov_flag` is 0.
- R2: A clock edge at which `vbst_code > ov_thr` makes every `pwm_inhibit` bit 1 right after that edge. A code equal to the trip code does not trip.
- R3: Once tripped, the phases stay inhibited until an edge at which `vbst_code + react_sel*HYST_STEP < ov_thr`. The release margin is `HYST_STEP` codes (default 1, about 0.5 V) per step of the 2-bit `react_sel`, so `react_sel` = 0 gives no margin.
- R4: `ov_flag` becomes 1 at the same edge as the trip and stays 1 while tripped, even when `stat_rd` is pulsed.
- R5: After release, `ov_flag` stays 1 until an edge with `stat_rd`=1 taken while released. That edge clears it, unless the same edge trips again.
- R6: After reset release, `uv_cmp` has no effect for the first `BLANK_CYC` (default 1500) clock edges.
- R7: Outside blanking, with `uv_thr` nonzero, the lock engages at the N-th consecutive edge with `uv_cmp`=1, where N = `uv_filt_len` (0 counts as 1). A low sample restarts the count.
- R8: `uv_thr` = 0 disables undervoltage detection. The lock releases at the first edge where `uv_cmp`=0 or `uv_thr`=0.
- R9: `phase_ok[i]` is the inverse of `pwm_inhibit[i]`. It is 0 during overvoltage trip and during undervoltage lock, and an undervoltage lock does not set `ov_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset; its release starts the blanking window |
| vbst_code | input | VCODE_W | Digitized boost output voltage |
| ov_thr | input | VCODE_W | Overvoltage trip code |
| react_sel | input | 2 | Release margin selection (steps of HYST_STEP codes) |
| uv_thr | input | UVTHR_W | Gate-drive undervoltage threshold selection; 0 disables |
| uv_cmp | input | 1 | Gate-drive undervoltage comparator, 1 = supply low |
| uv_filt_len | input | FILT_W | Consecutive cycles needed before undervoltage lock |
| stat_rd | input | 1 | One-cycle strobe of a status read |
| pwm_inhibit | output | NPHASE | Per-phase switching inhibit |
| phase_ok | output | NPHASE | Per-phase status, 1 = phase may switch |
| ov_flag | output | 1 | Sticky overvoltage flag, cleared by read after release |

## Verification
The assertions assume that all inputs are already synchronous to `clk` and that `stat_rd` is a strobe. They assume nothing about how long the threshold codes stay steady, so each property uses the codes sampled at the same edge. The stimulus changes inputs only at the falling edge, pulses `stat_rd` for single cycles, and holds `ov_thr` and the debounce length steady within each scenario. This keeps every expected value tied to one known edge count since reset release.

// File: rtl/boost_guard_pkg.sv
package boost_guard_pkg;
    typedef enum logic {
        OV_RUN  = 1'b0,
        OV_TRIP = 1'b1
    } ov_state_e;

    typedef enum logic [1:0] {
        UV_BLANK = 2'd0,
        UV_WATCH = 2'd1,
        UV_LOCK  = 2'd2
    } uv_state_e;
endpackage

// File: rtl/bg_ov_ctrl.sv
module bg_ov_ctrl
    import boost_guard_pkg::*;
#(
    parameter int VCODE_W   = 7,
    parameter int SEL_W     = 2,
    parameter int HYST_STEP = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [VCODE_W-1:0] vbst_code,
    input  logic [VCODE_W-1:0] ov_thr,
    input  logic [SEL_W-1:0]   react_sel,
    input  logic               stat_rd,
    output logic               ov_trip,
    output logic               ov_flag
);
    localparam int EXT_W = VCODE_W + SEL_W + 4;

    ov_state_e        st, st_nxt;
    logic [EXT_W-1:0] margin;
    logic [EXT_W-1:0] rel_level;
    logic             trip_req;
    logic             release_ok;

    always_comb begin
        margin     = EXT_W'(react_sel) * EXT_W'(HYST_STEP);
        rel_level  = EXT_W'(vbst_code) + margin;
        trip_req   = (vbst_code > ov_thr);
        release_ok = (rel_level < EXT_W'(ov_thr));
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            OV_RUN:  if (trip_req)   st_nxt = OV_TRIP;
            OV_TRIP: if (release_ok) st_nxt = OV_RUN;
            default: st_nxt = OV_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= OV_RUN;
        else        st <= st_nxt;
    end

    always_comb begin
        ov_trip = (st == OV_TRIP);
    end

    // sticky flag: a new trip wins over a read in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         ov_flag <= 1'b0;
        else if (st_nxt == OV_TRIP)         ov_flag <= 1'b1;
        else if (stat_rd && st == OV_RUN)   ov_flag <= 1'b0;
    end
endmodule

// File: rtl/bg_uv_ctrl.sv
module bg_uv_ctrl
    import boost_guard_pkg::*;
#(
    parameter int BLANK_CYC = 1500,
    parameter int FILT_W    = 9,
    parameter int UVTHR_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [UVTHR_W-1:0] uv_thr,
    input  logic               uv_cmp,
    input  logic [FILT_W-1:0]  filt_len,
    output logic               uv_lock,
    output logic               uv_blank
);
    localparam int BLK_W = (BLANK_CYC < 2) ? 1 : $clog2(BLANK_CYC);

    uv_state_e         st, st_nxt;
    logic [BLK_W-1:0]  blk_cnt, blk_nxt;
    logic [FILT_W-1:0] flt_cnt, flt_nxt;
    logic [FILT_W:0]   flt_inc;
    logic [FILT_W:0]   len_eff;
    logic              uv_act;

    always_comb begin
        uv_act  = (uv_thr != '0) && uv_cmp;
        flt_inc = {1'b0, flt_cnt} + 1'b1;
        len_eff = (filt_len == '0) ? (FILT_W+1)'(1) : {1'b0, filt_len};
    end

    always_comb begin
        st_nxt  = st;
        blk_nxt = blk_cnt;
        flt_nxt = flt_cnt;
        unique case (st)
            UV_BLANK: begin
                if (blk_cnt == BLK_W'(BLANK_CYC - 1)) begin
                    st_nxt  = UV_WATCH;
                    blk_nxt = '0;
                end else begin
                    blk_nxt = blk_cnt + 1'b1;
                end
            end
            UV_WATCH: begin
                if (uv_act) begin
                    if (flt_inc >= len_eff) begin
                        st_nxt  = UV_LOCK;
                        flt_nxt = '0;
                    end else begin
                        flt_nxt = flt_inc[FILT_W-1:0];
                    end
                end else begin
                    flt_nxt = '0;
                end
            end
            UV_LOCK: if (!uv_act) st_nxt = UV_WATCH;
            default: st_nxt = UV_BLANK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= UV_BLANK;
            blk_cnt <= '0;
            flt_cnt <= '0;
        end else begin
            st      <= st_nxt;
            blk_cnt <= blk_nxt;
            flt_cnt <= flt_nxt;
        end
    end

    always_comb begin
        uv_lock  = (st == UV_LOCK);
        uv_blank = (st == UV_BLANK);
    end
endmodule

// File: rtl/boost_guard.sv
module boost_guard #(
    parameter int NPHASE    = 3,
    parameter int VCODE_W   = 7,
    parameter int HYST_STEP = 1,
    parameter int BLANK_CYC = 1500,
    parameter int FILT_W    = 9,
    parameter int UVTHR_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [VCODE_W-1:0] vbst_code,
    input  logic [VCODE_W-1:0] ov_thr,
    input  logic [1:0]         react_sel,
    input  logic [UVTHR_W-1:0] uv_thr,
    input  logic               uv_cmp,
    input  logic [FILT_W-1:0]  uv_filt_len,
    input  logic               stat_rd,
    output logic [NPHASE-1:0]  pwm_inhibit,
    output logic [NPHASE-1:0]  phase_ok,
    output logic               ov_flag
);
    logic ov_trip;
    logic uv_lock;
    logic uv_blank;
    logic stop_all;

    bg_ov_ctrl #(
        .VCODE_W  (VCODE_W),
        .SEL_W    (2),
        .HYST_STEP(HYST_STEP)
    ) u_ov (
        .clk      (clk),
        .rst_n    (rst_n),
        .vbst_code(vbst_code),
        .ov_thr   (ov_thr),
        .react_sel(react_sel),
        .stat_rd  (stat_rd),
        .ov_trip  (ov_trip),
        .ov_flag  (ov_flag)
    );

    bg_uv_ctrl #(
        .BLANK_CYC(BLANK_CYC),
        .FILT_W   (FILT_W),
        .UVTHR_W  (UVTHR_W)
    ) u_uv (
        .clk     (clk),
        .rst_n   (rst_n),
        .uv_thr  (uv_thr),
        .uv_cmp  (uv_cmp),
        .filt_len(uv_filt_len),
        .uv_lock (uv_lock),
        .uv_blank(uv_blank)
    );

    assign stop_all = ov_trip | uv_lock;

    for (genvar gi = 0; gi < NPHASE; gi++) begin : g_phase
        assign pwm_inhibit[gi] = stop_all;
        assign phase_ok[gi]    = ~stop_all;
    end
endmodule

// File: rtl/boost_guard_chk.sv
module boost_guard_chk #(
    parameter int NPHASE    = 3,
    parameter int VCODE_W   = 7,
    parameter int HYST_STEP = 1,
    parameter int UVTHR_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [VCODE_W-1:0] vbst_code,
    input logic [VCODE_W-1:0] ov_thr,
    input logic [1:0]         react_sel,
    input logic [UVTHR_W-1:0] uv_thr,
    input logic               stat_rd,
    input logic [NPHASE-1:0]  pwm_inhibit,
    input logic [NPHASE-1:0]  phase_ok,
    input logic               ov_flag,
    input logic               ov_trip,
    input logic               uv_lock,
    input logic               uv_blank
);
    localparam int EW = VCODE_W + 6;

    logic [EW-1:0] rel_sum;
    assign rel_sum = EW'(vbst_code) + EW'(react_sel) * EW'(HYST_STEP);

    // R2: code above trip inhibits all phases after the edge
    p_trip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (vbst_code > ov_thr) |=> (&pwm_inhibit));

    // R3: tripped state held while the release level is not reached
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_trip && (rel_sum >= EW'(ov_thr))) |=> ov_trip);

    // R4: flag present whenever tripped
    p_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ov_trip |-> ov_flag);

    // R5: flag only drops on a read
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_flag && !stat_rd) |=> ov_flag);

    // R6: no lock while blanking
    p_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
        uv_blank |=> !uv_lock);

    // R8: disabled code prevents or releases lock
    p_uvoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_thr == '0) |=> !uv_lock);

    // R9: status bits all zero during any shutdown
    p_stat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_trip || uv_lock) |-> (phase_ok == '0) && (&pwm_inhibit));
endmodule

bind boost_guard boost_guard_chk #(
    .NPHASE   (NPHASE),
    .VCODE_W  (VCODE_W),
    .HYST_STEP(HYST_STEP),
    .UVTHR_W  (UVTHR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .vbst_code  (vbst_code),
    .ov_thr     (ov_thr),
    .react_sel  (react_sel),
    .uv_thr     (uv_thr),
    .stat_rd    (stat_rd),
    .pwm_inhibit(pwm_inhibit),
    .phase_ok   (phase_ok),
    .ov_flag    (ov_flag),
    .ov_trip    (ov_trip),
    .uv_lock    (uv_lock),
    .uv_blank   (uv_blank)
);

// File: tb/boost_guard_tb.sv
module boost_guard_tb;
    localparam int NPHASE    = 3;
    localparam int BLANK_CYC = 1500;
    localparam int NVEC      = 14;

    typedef struct packed {
        logic [6:0] v;
        logic [1:0] sel;
        logic       rd;
        logic       inh;
        logic       flg;
    } vec_t;

    // trip code fixed at 100, undervoltage disabled
    localparam vec_t VECS [NVEC] = '{
        '{7'd90,  2'd2, 1'b0, 1'b0, 1'b0},  // below trip
        '{7'd100, 2'd2, 1'b0, 1'b0, 1'b0},  // equal: no trip (R2)
        '{7'd101, 2'd2, 1'b0, 1'b1, 1'b1},  // trip (R2)
        '{7'd99,  2'd2, 1'b1, 1'b1, 1'b1},  // read while tripped (R4)
        '{7'd98,  2'd2, 1'b0, 1'b1, 1'b1},  // 98+2 not below 100 (R3)
        '{7'd97,  2'd2, 1'b0, 1'b0, 1'b1},  // release, flag sticky (R3)
        '{7'd97,  2'd2, 1'b0, 1'b0, 1'b1},  // still sticky (R5)
        '{7'd97,  2'd2, 1'b1, 1'b0, 1'b0},  // read clears (R5)
        '{7'd120, 2'd0, 1'b0, 1'b1, 1'b1},  // trip again
        '{7'd99,  2'd0, 1'b0, 1'b0, 1'b1},  // zero margin release (R3)
        '{7'd101, 2'd3, 1'b1, 1'b1, 1'b1},  // trip beats read (R5)
        '{7'd97,  2'd3, 1'b0, 1'b1, 1'b1},  // 97+3 not below 100 (R3)
        '{7'd96,  2'd3, 1'b1, 1'b0, 1'b1},  // read on release edge keeps flag
        '{7'd96,  2'd3, 1'b1, 1'b0, 1'b0}   // read after release clears
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic [6:0]        vbst_code;
    logic [6:0]        ov_thr;
    logic [1:0]        react_sel;
    logic [2:0]        uv_thr;
    logic              uv_cmp;
    logic [8:0]        uv_filt_len;
    logic              stat_rd;
    logic [NPHASE-1:0] pwm_inhibit;
    logic [NPHASE-1:0] phase_ok;
    logic              ov_flag;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    boost_guard #(.NPHASE(NPHASE), .BLANK_CYC(BLANK_CYC)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .vbst_code  (vbst_code),
        .ov_thr     (ov_thr),
        .react_sel  (react_sel),
        .uv_thr     (uv_thr),
        .uv_cmp     (uv_cmp),
        .uv_filt_len(uv_filt_len),
        .stat_rd    (stat_rd),
        .pwm_inhibit(pwm_inhibit),
        .phase_ok   (phase_ok),
        .ov_flag    (ov_flag)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0; vbst_code = '0; ov_thr = 7'd100; react_sel = '0;
        uv_thr = '0; uv_cmp = 1'b0; uv_filt_len = 9'd4; stat_rd = 1'b0;
        @(negedge clk);
        do_reset();
        vbst_code = 7'd120;  // ignored until the first edge
        check("R1 inhibit after reset", int'(pwm_inhibit), 0);
        check("R1 phase_ok after reset", int'(phase_ok), (1 << NPHASE) - 1);
        check("R1 flag after reset", int'(ov_flag), 0);
        vbst_code = 7'd0;

        for (int i = 0; i < NVEC; i++) begin
            vbst_code = VECS[i].v;
            react_sel = VECS[i].sel;
            stat_rd   = VECS[i].rd;
            step();
            stat_rd = 1'b0;
            check($sformatf("R2 R3 R4 R5 vector %0d inhibit", i),
                  int'(pwm_inhibit), VECS[i].inh ? (1 << NPHASE) - 1 : 0);
            check($sformatf("R9 vector %0d phase_ok", i),
                  int'(phase_ok), VECS[i].inh ? 0 : (1 << NPHASE) - 1);
            check($sformatf("R4 R5 vector %0d flag", i),
                  int'(ov_flag), int'(VECS[i].flg));
        end

        // undervoltage part
        vbst_code = 7'd0; react_sel = '0;
        do_reset();
        uv_thr = 3'd3; uv_cmp = 1'b1; uv_filt_len = 9'd4;
        repeat (BLANK_CYC - 1) step();
        check("R6 comparator ignored in blanking", int'(pwm_inhibit), 0);
        step();
        check("R6 window just expired", int'(pwm_inhibit), 0);
        repeat (3) step();
        check("R7 three of four samples", int'(pwm_inhibit), 0);
        step();
        check("R7 lock after four samples", int'(pwm_inhibit), (1 << NPHASE) - 1);
        check("R9 phase_ok in lock", int'(phase_ok), 0);
        check("R9 lock leaves flag clear", int'(ov_flag), 0);
        uv_cmp = 1'b0;
        step();
        check("R8 comparator low releases", int'(pwm_inhibit), 0);
        uv_cmp = 1'b1;
        repeat (3) step();
        uv_cmp = 1'b0;
        step();
        uv_cmp = 1'b1;
        repeat (3) step();
        check("R7 interrupted run restarts", int'(pwm_inhibit), 0);
        step();
        check("R7 lock after fresh run", int'(pwm_inhibit), (1 << NPHASE) - 1);
        uv_thr = 3'd0;
        step();
        check("R8 disabled releases lock", int'(pwm_inhibit), 0);
        repeat (10) step();
        check("R8 disabled stays off", int'(pwm_inhibit), 0);
        uv_thr = 3'd5; uv_filt_len = 9'd0;
        step();
        check("R7 zero length locks in one", int'(pwm_inhibit), (1 << NPHASE) - 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule